// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks one address reservation for each of `NCTX` processor contexts that share memory. It lets those contexts build atomic read-modify-write sequences from a load-linked read and a store-conditional write. It watches every memory request and decides, in the request's own cycle, whether the memory may accept a conditional store. It reports the conditional's result flag. When any store is allowed to reach memory, it drops every reservation that store overlaps.

Addresses are compared on aligned blocks of `2**BLK_BITS` bytes, which is 16 bytes by default. Each context also keeps a count of its back-to-back failed conditionals. A one-cycle warning fires every `WARN_PERIOD` failures so that a livelocked software loop can be spotted.

The memory array, caches and address translation sit outside this block. One request is presented per cycle, and `req_ctx` must be below `NCTX`.

Top module: `llsc_monitor`

## Requirements
- R1: A request with `req_valid=1`, `req_write=0` and `req_locked=1` records `req_addr` as the reservation of context `req_ctx` and sets its reservation flag. This takes effect at the next clock edge.
- R2: For a conditional store (`req_valid=1`, `req_write=1`, `req_locked=1`, `req_uncached=0`), `sc_valid` is 1 in the same cycle. `sc_result` then equals the issuing context's reservation flag as it stood before the store, even when the address check fails.
- R3: A conditional store raises `commit_en` in the same cycle only if the issuing context's flag is set and its reserved address equals `req_addr` with bits `[BLK_BITS-1:0]` ignored.
- R4: A conditional store that fails R3 keeps `commit_en` at 0 and clears the issuing context's flag.
- R5: Each failed conditional adds one to that context's slice of `fail_count` at the next edge. Whenever the new count is a multiple of `WARN_PERIOD`, `warn[ctx]` is 1 for exactly the following cycle.
- R6: A successful conditional store sets the issuing context's failure count to zero.
- R7: A plain store (`req_valid=1`, `req_write=1`, `req_locked=0`) always raises `commit_en`. Every committed store, whether plain, successful conditional or uncached conditional, clears the flag of each context whose reserved block equals the store's block. Contexts with other blocks keep their flags.
- R8: A conditional store with `req_uncached=1` skips the reservation check. It gives `sc_valid=0`, raises `commit_en`, and zeroes that context's failure count.
- R9: Plain reads and idle cycles leave every reservation unchanged.
- R10: While `rst_n` is low, all flags, failure counts and warnings are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A memory request is present this cycle |
| req_ctx | input | CTXW | Issuing context index |
| req_addr | input | AW | Physical byte address |
| req_locked | input | 1 | Load-linked (read) or store-conditional (write) |
| req_write | input | 1 | Request is a store |
| req_uncached | input | 1 | Target lies in uncacheable space |
| sc_valid | output | 1 | A conditional result is reported this cycle |
| sc_result | output | 1 | Conditional result flag |
| commit_en | output | 1 | Memory may perform the store this cycle |
| fail_count | output | NCTX*CW | Per-context consecutive failure counts, context c at `[c*CW +: CW]` |
| warn | output | NCTX | One-cycle per-context livelock warning |

## Verification
`sc_valid`, `sc_result` and `commit_en` are combinational, so they are due in the request's own cycle. The bench samples them one time unit after driving the request, well before the next edge. Reservation changes, `fail_count` and `warn` all become visible one edge after the request. The bench samples them one time unit after that edge, against a behavioural model that advances by one request per clock. Changes to reservations are observed through later conditional stores, which report each flag through `sc_result` and `commit_en`.

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int NCTX        = 4,
  parameter int AW          = 32,
  parameter int BLK_BITS    = 4,
  parameter int CW          = 32,
  parameter int WARN_PERIOD = 100000,
  localparam int CTXW = (NCTX > 1) ? $clog2(NCTX) : 1,
  localparam int PW   = (WARN_PERIOD > 1) ? $clog2(WARN_PERIOD) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [CTXW-1:0]    req_ctx,
  input  logic [AW-1:0]      req_addr,
  input  logic               req_locked,
  input  logic               req_write,
  input  logic               req_uncached,
  output logic               sc_valid,
  output logic               sc_result,
  output logic               commit_en,
  output logic [NCTX*CW-1:0] fail_count,
  output logic [NCTX-1:0]    warn
);

  logic [NCTX-1:0] lock_flag;
  logic [AW-1:0]   lock_addr [NCTX];

  wire is_ll  = req_valid & ~req_write & req_locked;
  wire is_sc  = req_valid &  req_write & req_locked;
  wire is_st  = req_valid &  req_write & ~req_locked;
  wire own_fl = lock_flag[req_ctx];
  wire own_eq = lock_addr[req_ctx][AW-1:BLK_BITS] == req_addr[AW-1:BLK_BITS];
  wire sc_ok  = own_fl & own_eq;
  wire sc_bad = sc_valid & ~sc_ok;

  assign sc_valid  = is_sc & ~req_uncached;
  assign sc_result = sc_valid & own_fl;
  assign commit_en = is_st | (is_sc & (req_uncached | sc_ok));

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    logic [CW-1:0] cnt;
    logic [PW-1:0] phase;
    wire sel = req_ctx == CTXW'(c);
    wire hit = lock_addr[c][AW-1:BLK_BITS] == req_addr[AW-1:BLK_BITS];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lock_flag[c] <= 1'b0;
        lock_addr[c] <= '0;
      end else if (is_ll && sel) begin
        lock_flag[c] <= 1'b1;
        lock_addr[c] <= req_addr;
      end else if ((commit_en && hit) || (sc_bad && sel)) begin
        lock_flag[c] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt     <= '0;
        phase   <= '0;
        warn[c] <= 1'b0;
      end else begin
        warn[c] <= 1'b0;
        if (sc_bad && sel) begin
          cnt <= cnt + CW'(1);
          if (phase == PW'(WARN_PERIOD - 1)) begin
            phase   <= '0;
            warn[c] <= 1'b1;
          end else begin
            phase <= phase + PW'(1);
          end
        end else if (is_sc && commit_en && sel) begin
          cnt   <= '0;
          phase <= '0;
        end
      end
    end

    assign fail_count[c*CW +: CW] = cnt;
  end

endmodule

module llsc_monitor_chk #(
  parameter int NCTX = 4,
  parameter int CW   = 32,
  parameter int CTXW = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [CTXW-1:0]    req_ctx,
  input logic               req_locked,
  input logic               req_write,
  input logic               req_uncached,
  input logic               sc_valid,
  input logic               sc_result,
  input logic               commit_en,
  input logic [NCTX*CW-1:0] fail_count,
  input logic [NCTX-1:0]    warn,
  input logic [NCTX-1:0]    lock_flag
);

  a_r1_ll_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && req_locked |=> lock_flag[$past(req_ctx)]);

  a_r4_fail_blocks_commit: assert property (@(posedge clk) disable iff (!rst_n)
    sc_valid && !sc_result |-> !commit_en);

  a_r4_fail_clears_own: assert property (@(posedge clk) disable iff (!rst_n)
    sc_valid && !commit_en |=> !lock_flag[$past(req_ctx)]);

  a_r5_fail_counts_up: assert property (@(posedge clk) disable iff (!rst_n)
    sc_valid && !commit_en |=>
      fail_count[$past(req_ctx)*CW +: CW] == $past(fail_count[req_ctx*CW +: CW]) + CW'(1));

  a_r5_single_warning: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(warn));

  a_r6_pass_resets_count: assert property (@(posedge clk) disable iff (!rst_n)
    sc_valid && commit_en |=> fail_count[$past(req_ctx)*CW +: CW] == '0);

  a_r8_uncached_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && req_locked && req_uncached |-> !sc_valid && commit_en);

  a_r9_reads_keep_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid || (!req_write && !req_locked) |=> $stable(lock_flag));

endmodule

bind llsc_monitor llsc_monitor_chk #(.NCTX(NCTX), .CW(CW), .CTXW(CTXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ctx(req_ctx),
  .req_locked(req_locked), .req_write(req_write), .req_uncached(req_uncached),
  .sc_valid(sc_valid), .sc_result(sc_result), .commit_en(commit_en),
  .fail_count(fail_count), .warn(warn), .lock_flag(lock_flag)
);

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCTX = 4;
  localparam int AW   = 32;
  localparam int BLK  = 4;
  localparam int CW   = 32;
  localparam int WP   = 5;
  localparam int CTXW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_locked = 1'b0, req_write = 1'b0, req_uncached = 1'b0;
  logic [CTXW-1:0] req_ctx = '0;
  logic [AW-1:0] req_addr = '0;
  logic sc_valid, sc_result, commit_en;
  logic [NCTX*CW-1:0] fail_count;
  logic [NCTX-1:0] warn;

  always #(CLK_PERIOD/2) clk = ~clk;

  llsc_monitor #(.NCTX(NCTX), .AW(AW), .BLK_BITS(BLK), .CW(CW), .WARN_PERIOD(WP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ctx(req_ctx), .req_addr(req_addr),
    .req_locked(req_locked), .req_write(req_write), .req_uncached(req_uncached),
    .sc_valid(sc_valid), .sc_result(sc_result), .commit_en(commit_en),
    .fail_count(fail_count), .warn(warn));

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit m_flag [NCTX];
  logic [AW-1:0] m_addr [NCTX];
  int unsigned m_cnt [NCTX];
  bit m_warn [NCTX];

  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_regs(string tag);
    for (int c = 0; c < NCTX; c++) begin
      chk(tag, $sformatf("fail_count[%0d]", c), fail_count[c*CW +: CW], m_cnt[c]);
      chk(tag, $sformatf("warn[%0d]", c), warn[c], m_warn[c]);
    end
  endtask

  task automatic step(string tag, bit v, int ctx, logic [AW-1:0] a, bit lk, bit wr, bit uc);
    bit e_scv, e_res, e_com, pass;
    req_valid = v; req_ctx = CTXW'(ctx); req_addr = a;
    req_locked = lk; req_write = wr; req_uncached = uc;
    #1;
    pass  = m_flag[ctx] && ((m_addr[ctx] >> BLK) == (a >> BLK));
    e_scv = v && wr && lk && !uc;
    e_res = e_scv && m_flag[ctx];
    e_com = v && wr && (!lk || uc || pass);
    chk(tag, "sc_valid", sc_valid, e_scv);
    chk(tag, "sc_result", sc_result, e_res);
    chk(tag, "commit_en", commit_en, e_com);
    for (int c = 0; c < NCTX; c++) m_warn[c] = 0;
    if (v && !wr && lk) begin
      m_flag[ctx] = 1;
      m_addr[ctx] = a;
    end else if (v && wr) begin
      if (e_com) begin
        for (int c = 0; c < NCTX; c++)
          if ((m_addr[c] >> BLK) == (a >> BLK)) m_flag[c] = 0;
        if (lk) m_cnt[ctx] = 0;
      end else begin
        m_flag[ctx] = 0;
        m_cnt[ctx]++;
        if (m_cnt[ctx] % WP == 0) m_warn[ctx] = 1;
      end
    end
    @(posedge clk); #1;
    check_regs(tag);
  endtask

  task automatic do_reset();
    rst_n = 0; req_valid = 0;
    repeat (2) @(posedge clk);
    #1;
    for (int c = 0; c < NCTX; c++) begin
      m_flag[c] = 0; m_addr[c] = '0; m_cnt[c] = 0; m_warn[c] = 0;
    end
    check_regs("R10");
    rst_n = 1;
  endtask

  task automatic ll(string t, int c, logic [AW-1:0] a); step(t, 1, c, a, 1, 0, 0); endtask
  task automatic sc(string t, int c, logic [AW-1:0] a); step(t, 1, c, a, 1, 1, 0); endtask
  task automatic st(string t, int c, logic [AW-1:0] a); step(t, 1, c, a, 0, 1, 0); endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    do_reset();
    sc("R10", 0, 32'h100);
    ll("R1", 0, 32'h100);
    sc("R3", 0, 32'h10C);
    ll("R1", 1, 32'h200);
    sc("R2", 1, 32'h210);
    sc("R4", 1, 32'h200);
    ll("R7", 0, 32'h300);
    ll("R7", 2, 32'h30C);
    ll("R7", 3, 32'h400);
    st("R7", 1, 32'h308);
    sc("R7", 3, 32'h400);
    sc("R7", 0, 32'h300);
    sc("R7", 2, 32'h300);
    ll("R9", 2, 32'h500);
    step("R9", 1, 1, 32'h500, 0, 0, 0);
    step("R9", 0, 3, 32'h500, 1, 1, 0);
    step("R9", 1, 3, 32'h504, 0, 0, 1);
    sc("R9", 2, 32'h500);
    for (int i = 0; i < 12; i++) sc("R5", 1, 32'h800);
    ll("R6", 1, 32'h800);
    sc("R6", 1, 32'h804);
    sc("R4", 2, 32'h900);
    sc("R4", 2, 32'h900);
    ll("R8", 0, 32'h600);
    step("R8", 1, 2, 32'h608, 1, 1, 1);
    sc("R8", 0, 32'h600);
    ll("R3", 3, 32'h0FF);
    sc("R3", 3, 32'h0F0);
    for (int i = 0; i < 7; i++) sc("R5", 3, 32'h40);
    do_reset();
    sc("R10", 3, 32'h0F0);
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 9);
      int c = $urandom_range(0, NCTX - 1);
      logic [AW-1:0] a = 32'h1000 + 32'($urandom_range(0, 3) * 16 + $urandom_range(0, 15));
      case (op)
        0, 1, 2: ll("R1", c, a);
        3, 4, 5: sc("R3", c, a);
        6:       st("R7", c, a);
        7:       step("R8", 1, c, a, 1, 1, 1);
        8:       step("R9", 1, c, a, 0, 0, 0);
        default: step("R9", 0, c, a, 0, 0, 0);
      endcase
    end
    done = 1;
    finish_run();
  end
endmodule